// File: doc/BRIEF.md
# Matrix-Addressed Nibble Data Memory

This block is the working data store of a small 4-bit controller. It holds 160 four-bit digits arranged as 10 files of 16 digits. A digit is picked by a file number and a digit number, which the surrounding datapath supplies from its two index registers. One operation is presented per cycle as a strobe with an opcode. The addressed digit is visible combinationally on `rd_data`, and every change to the store lands on the rising clock edge. An exchange therefore completes in one cycle: the old digit goes back to the accumulator while the new one is written.

File 9 doubles as a window of sixteen directly reachable memory registers. The memory-register exchange selects one of them by a 4-bit index and ignores the file and digit inputs. Single-bit set, clear and test act on the addressed digit, with the bit picked by a 2-bit operand. A bit test loads a one-bit status flag that the sequencer uses for conditional execution.

The block has no back-pressure. An operation is accepted in every cycle in which `op_valid` is high, so there is no ready signal. With `op_valid` low the store and the flag hold their values. Opcode encoding on `op_code`: 0 no-op, 1 read, 2 write, 3 exchange, 4 memory-register exchange, 5 bit set, 6 bit clear, 7 bit test.

Top module: `nibble_matrix_ram`

## Requirements
- R1: While `rst_n` is low, every digit becomes 0 and the status flag becomes 1.
- R2: `rd_data` shows, combinationally, the digit at file `x_sel` and digit `y_sel` when `x_sel` is 0 to 9 and `op_code` is not 4.
- R3: A write (code 2) stores `acc_in` at the addressed digit on the next rising edge.
- R4: An exchange (code 3) shows the old digit on `rd_data` in its own cycle and stores `acc_in` on the edge. The value written never appears on `rd_data` in that cycle.
- R5: A memory-register exchange (code 4) addresses file 9, digit `mr_idx`, whatever `x_sel` and `y_sel` hold. It shows the old digit and stores `acc_in`.
- R6: Memory register k is the same storage as file 9, digit k. A change made through either path is seen through the other.
- R7: With `x_sel` of 10 or more (and code not 4), `rd_data` is 0. A write, exchange, bit set or bit clear then changes no digit.
- R8: Bit set (code 5) forces bit `bit_n` of the addressed digit to 1 and leaves its other bits unchanged. `bit_n` = 0 is the least significant bit.
- R9: Bit clear (code 6) forces bit `bit_n` of the addressed digit to 0 and leaves its other bits unchanged.
- R10: Bit test (code 7) loads `status` on the edge with bit `bit_n` of the addressed digit. An out-of-range file reads as 0, so the flag is loaded with 0.
- R11: `status` changes only on a bit test, and nothing changes while `op_valid` is low.
- R12: A no-op (code 0) or a read (code 1) leaves every digit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 3 | Operation code, see encoding above |
| x_sel | input | 4 | File number |
| y_sel | input | 4 | Digit number within the file |
| mr_idx | input | 4 | Memory-register index for code 4 |
| bit_n | input | 2 | Bit select for the bit operations |
| acc_in | input | 4 | Accumulator value to be stored |
| rd_data | output | 4 | Addressed digit (old content) |
| status | output | 1 | Status flag, loaded by a bit test |

## Verification
Two functions share a single cycle. An exchange or memory-register exchange reads the old digit and commits the new one in the same cycle, and a bit set or clear reads and rewrites one digit in that cycle. The bench provokes these cases by choosing an accumulator value that differs from the stored digit. It checks `rd_data` before the edge and the stored result after the edge, so a design that forwards the write or loses the old value is caught. The second overlap is the memory-register window against matrix addressing. The bench writes through one path and reads through the other in the next cycle, and it presents unrelated `x_sel` and `y_sel` values during the memory-register exchange, so that a window decoded from the wrong inputs shows a mismatch.

// File: rtl/nibram_pkg.sv
package nibram_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_XCH   = 3'd3,
    OP_XMR   = 3'd4,
    OP_BSET  = 3'd5,
    OP_BCLR  = 3'd6,
    OP_BTST  = 3'd7
  } nib_op_e;

  // True for every operation that commits a digit on the edge.
  function automatic logic op_commits(nib_op_e op);
    case (op)
      OP_WRITE, OP_XCH, OP_XMR, OP_BSET, OP_BCLR: op_commits = 1'b1;
      default:                                    op_commits = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/nibram_addr.sv
module nibram_addr
  import nibram_pkg::*;
#(
  parameter int FILES   = 10,
  parameter int XW      = 4,
  parameter int YW      = 4,
  parameter int MR_FILE = 9
) (
  input  nib_op_e         op,
  input  logic [XW-1:0]   x_sel,
  input  logic [YW-1:0]   y_sel,
  input  logic [YW-1:0]   mr_idx,
  output logic [XW-1:0]   file_idx,
  output logic [YW-1:0]   dig_idx,
  output logic            in_range
);
  localparam logic [XW-1:0] MR_F = XW'(MR_FILE);
  localparam logic [XW-1:0] LIM  = XW'(FILES);

  always_comb begin
    if (op == OP_XMR) begin
      file_idx = MR_F;
      dig_idx  = mr_idx;
    end else begin
      file_idx = x_sel;
      dig_idx  = y_sel;
    end
    in_range = (file_idx < LIM);
  end
endmodule

// File: rtl/nibram_store.sv
module nibram_store #(
  parameter int FILES  = 10,
  parameter int DIGITS = 16,
  parameter int NIB    = 4,
  parameter int XW     = 4,
  parameter int YW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XW-1:0]   file_idx,
  input  logic [YW-1:0]   dig_idx,
  input  logic [NIB-1:0]  wdata,
  output logic [NIB-1:0]  rdata
);
  logic [NIB-1:0] file_rd [FILES];

  for (genvar f = 0; f < FILES; f++) begin : g_file
    logic [DIGITS-1:0][NIB-1:0] row;
    logic                       hit;
    assign hit = (file_idx == XW'(f));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row <= '0;
      end else if (we && hit) begin
        row[dig_idx] <= wdata;
      end
    end

    assign file_rd[f] = row[dig_idx];
  end

  always_comb begin
    rdata = '0;
    for (int f = 0; f < FILES; f++) begin
      if (file_idx == XW'(f)) rdata = file_rd[f];
    end
  end
endmodule

// File: rtl/nibram_bitunit.sv
module nibram_bitunit
  import nibram_pkg::*;
#(
  parameter int NIB = 4,
  parameter int NW  = 2
) (
  input  nib_op_e         op,
  input  logic [NIB-1:0]  old_nib,
  input  logic [NIB-1:0]  acc_in,
  input  logic [NW-1:0]   bit_n,
  output logic [NIB-1:0]  new_nib,
  output logic            tbit
);
  logic [NIB-1:0] mask;

  always_comb begin
    mask = '0;
    mask[bit_n] = 1'b1;
    tbit = old_nib[bit_n];
    case (op)
      OP_BSET: new_nib = old_nib | mask;
      OP_BCLR: new_nib = old_nib & ~mask;
      default: new_nib = acc_in;
    endcase
  end
endmodule

// File: rtl/nibram_flag.sv
module nibram_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic din,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b1;
    else if (load) flag <= din;
  end
endmodule

// File: rtl/nibble_matrix_ram.sv
module nibble_matrix_ram
  import nibram_pkg::*;
#(
  parameter int FILES   = 10,
  parameter int DIGITS  = 16,
  parameter int NIB     = 4,
  parameter int XW      = 4,
  parameter int MR_FILE = 9,
  localparam int YW     = $clog2(DIGITS),
  localparam int NW     = $clog2(NIB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [XW-1:0]   x_sel,
  input  logic [YW-1:0]   y_sel,
  input  logic [YW-1:0]   mr_idx,
  input  logic [NW-1:0]   bit_n,
  input  logic [NIB-1:0]  acc_in,
  output logic [NIB-1:0]  rd_data,
  output logic            status
);
  nib_op_e        op;
  logic [XW-1:0]  file_idx;
  logic [YW-1:0]  dig_idx;
  logic           in_range;
  logic [NIB-1:0] new_nib;
  logic           tbit;
  logic           wr_en;

  assign op = nib_op_e'(op_code);

  nibram_addr #(.FILES(FILES), .XW(XW), .YW(YW), .MR_FILE(MR_FILE)) u_addr (
    .op(op), .x_sel(x_sel), .y_sel(y_sel), .mr_idx(mr_idx),
    .file_idx(file_idx), .dig_idx(dig_idx), .in_range(in_range)
  );

  nibram_store #(.FILES(FILES), .DIGITS(DIGITS), .NIB(NIB), .XW(XW), .YW(YW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .file_idx(file_idx),
    .dig_idx(dig_idx), .wdata(new_nib), .rdata(rd_data)
  );

  nibram_bitunit #(.NIB(NIB), .NW(NW)) u_bits (
    .op(op), .old_nib(rd_data), .acc_in(acc_in), .bit_n(bit_n),
    .new_nib(new_nib), .tbit(tbit)
  );

  assign wr_en = op_valid && in_range && op_commits(op);

  nibram_flag u_flag (
    .clk(clk), .rst_n(rst_n), .load(op_valid && (op == OP_BTST)),
    .din(tbit), .flag(status)
  );
endmodule

// File: rtl/nibble_matrix_ram_chk.sv
module nibble_matrix_ram_chk #(
  parameter int FILES   = 10,
  parameter int XW      = 4,
  parameter int YW      = 4,
  parameter int NW      = 2,
  parameter int NIB     = 4,
  parameter int MR_FILE = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [2:0]      op_code,
  input logic [XW-1:0]   x_sel,
  input logic [YW-1:0]   y_sel,
  input logic [YW-1:0]   mr_idx,
  input logic [NW-1:0]   bit_n,
  input logic [NIB-1:0]  acc_in,
  input logic [NIB-1:0]  rd_data,
  input logic            status
);
  localparam logic [XW-1:0] LIM  = XW'(FILES);
  localparam logic [XW-1:0] MR_F = XW'(MR_FILE);

  // R7
  oob_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_sel >= LIM && op_code != 3'd4) |-> rd_data == '0);

  // R10
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd7) |=> status == $past(rd_data[bit_n]));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code == 3'd7) |=> $stable(status));

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2 && x_sel < LIM) |=>
      (!(x_sel == $past(x_sel) && y_sel == $past(y_sel) && op_code != 3'd4)
       || rd_data == $past(acc_in)));

  // R6
  mr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=>
      (!(x_sel == MR_F && y_sel == $past(mr_idx) && op_code != 3'd4)
       || rd_data == $past(acc_in)));

  // R8
  bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd5 && x_sel < LIM) |=>
      (!(x_sel == $past(x_sel) && y_sel == $past(y_sel) && op_code != 3'd4)
       || rd_data == ($past(rd_data) | NIB'(1 << $past(bit_n)))));

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && $stable(x_sel) && $stable(y_sel) && $stable(op_code)) |=>
      (!($stable(x_sel) && $stable(y_sel) && $stable(op_code) && $stable(mr_idx))
       || rd_data == $past(rd_data)));
endmodule

bind nibble_matrix_ram nibble_matrix_ram_chk #(
  .FILES(FILES), .XW(XW), .YW(YW), .NW(NW), .NIB(NIB), .MR_FILE(MR_FILE)
) u_chk (.*);

// File: tb/nibble_matrix_ram_bench.sv
`timescale 1ns/1ps
module nibble_matrix_ram_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [3:0] x_sel = '0, y_sel = '0, mr_idx = '0, acc_in = '0;
  logic [1:0] bit_n = '0;
  logic [3:0] rd_data;
  logic       status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nibble_matrix_ram u_nibble_matrix_ram (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .x_sel(x_sel), .y_sel(y_sel), .mr_idx(mr_idx), .bit_n(bit_n),
    .acc_in(acc_in), .rd_data(rd_data), .status(status)
  );

  // vector: op, x, y, mr, n, acc, expected rd_data, expected status after edge, req
  function automatic logic [29:0] mk(input int op, x, y, mr, n, acc, rd, st, rq);
    return {3'(op), 4'(x), 4'(y), 4'(mr), 2'(n), 4'(acc), 4'(rd), 1'(st), 4'(rq)};
  endfunction

  localparam int NV = 30;
  localparam logic [29:0] VEC [NV] = '{
    mk(2, 0, 0, 0, 0, 5, 0, 1, 3),    // R3 write 5
    mk(1, 0, 0, 0, 0, 0, 5, 1, 2),    // R2 read back
    mk(2, 9, 15, 0, 0, 10, 0, 1, 3),  // R3
    mk(3, 9, 15, 0, 0, 3, 10, 1, 4),  // R4 old shown
    mk(1, 9, 15, 0, 0, 0, 3, 1, 4),   // R4 new stored
    mk(4, 0, 0, 15, 0, 7, 3, 1, 5),   // R5 ignores x/y
    mk(1, 9, 15, 0, 0, 0, 7, 1, 6),   // R6 alias
    mk(2, 9, 2, 0, 0, 12, 0, 1, 6),   // R6 write via matrix
    mk(4, 3, 4, 2, 0, 1, 12, 1, 6),   // R6 seen as MR2
    mk(1, 9, 2, 0, 0, 0, 1, 1, 5),    // R5
    mk(7, 0, 0, 0, 0, 0, 5, 1, 10),   // R10 bit0 of 5
    mk(7, 0, 0, 0, 1, 0, 5, 0, 10),   // R10 bit1 of 5
    mk(1, 0, 0, 0, 0, 0, 5, 0, 11),   // R11 flag held
    mk(5, 0, 0, 0, 1, 0, 5, 0, 8),    // R8 set bit1
    mk(1, 0, 0, 0, 0, 0, 7, 0, 8),    // R8
    mk(6, 0, 0, 0, 0, 0, 7, 0, 9),    // R9 clear bit0
    mk(1, 0, 0, 0, 0, 0, 6, 0, 9),    // R9
    mk(7, 0, 0, 0, 2, 0, 6, 1, 10),   // R10 bit2 of 6
    mk(5, 0, 0, 0, 3, 0, 6, 1, 8),    // R8 set msb
    mk(1, 0, 0, 0, 0, 0, 14, 1, 8),   // R8
    mk(2, 10, 0, 0, 0, 15, 0, 1, 7),  // R7 oob write
    mk(1, 15, 3, 0, 0, 0, 0, 1, 7),   // R7 oob read
    mk(7, 12, 0, 0, 0, 0, 0, 0, 10),  // R10 oob test -> 0
    mk(5, 10, 0, 0, 0, 0, 0, 0, 7),   // R7 oob set
    mk(1, 0, 0, 0, 0, 0, 14, 0, 7),   // R7 file 0 untouched
    mk(0, 0, 0, 0, 0, 1, 14, 0, 12),  // R12 nop
    mk(1, 0, 0, 0, 0, 3, 14, 0, 12),  // R12 read, acc ignored
    mk(2, 5, 7, 0, 0, 9, 0, 0, 3),    // R3
    mk(1, 5, 7, 0, 0, 0, 9, 0, 2),    // R2
    mk(1, 5, 6, 0, 0, 0, 0, 0, 2)     // R2 neighbour clean
  };

  task automatic chk(input string rq, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(input int op, x, y, mr, n, acc, input logic v);
    @(negedge clk);
    op_valid = v; op_code = 3'(op); x_sel = 4'(x); y_sel = 4'(y);
    mr_idx = 4'(mr); bit_n = 2'(n); acc_in = 4'(acc);
  endtask

  task automatic peek(input int x, y, input logic [3:0] exp, input string rq);
    drive(1, x, y, 0, 0, 0, 1'b0);
    #1 chk(rq, rd_data, exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1", {3'b0, status}, 4'd1);
    chk("R1", rd_data, 4'd0);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", int'(v[3:0]));
      drive(int'(v[29:27]), int'(v[26:23]), int'(v[22:19]), int'(v[18:15]),
            int'(v[14:13]), int'(v[12:9]), 1'b1);
      #1 chk(rq, rd_data, v[8:5]);
      @(posedge clk); #1;
      chk(rq, {3'b0, status}, {3'b0, v[4]});
    end

    // R11: strobe low, write request ignored
    drive(2, 5, 7, 0, 0, 0, 1'b0);
    @(posedge clk);
    peek(5, 7, 4'd9, "R11");
    // R11: bit test with strobe low leaves flag
    drive(7, 5, 7, 0, 0, 0, 1'b0);
    @(posedge clk); #1 chk("R11", {3'b0, status}, 4'd0);
    // R5: exchange through MR while x is out of range
    drive(4, 14, 9, 7, 0, 6, 1'b1);
    #1 chk("R5", rd_data, 4'd0);
    @(posedge clk);
    peek(9, 7, 4'd6, "R6");
    // R1: reset mid-run clears store and presets flag
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk); rst_n = 1'b1;
    #1 chk("R1", {3'b0, status}, 4'd1);
    peek(5, 7, 4'd0, "R1");
    peek(0, 0, 4'd0, "R1");
    peek(9, 7, 4'd0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule